// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one pulse-width command into two complementary gate enables for a synchronous half-bridge. It holds off each turn-on until sensed conditions show that the opposite switch has really stopped conducting, rather than counting a fixed blanking interval. Three digitized comparator flags come in: the low-side gate has fallen below its turn-off level, the high-side gate has fallen below its turn-off level, and the switch node has fallen low. Each flag first passes through a two-flop synchronizer. Once the watched condition is seen, a short fixed delay runs, and then the opposite gate is enabled.

The rising command edge always waits on the low-side gate flag. The falling edge depends on a mode pin. In symmetric mode it waits on the high-side gate flag, so the sequence is the same whichever way power flows. In asymmetric mode it waits on the switch-node flag. If the high-side gate is already off but the node stays high, as happens with reverse current, a long timeout runs instead and the low-side gate is then enabled without the short delay. A command change in the middle of a sequence cancels the pending turn-on and starts the sequence for the new level. All pins are plain level signals sampled on the clock, so the block has no streaming interface and no back-pressure.

Top module: `dt_gate_sequencer`

## Requirements
- R1: A synchronous active-high `rst` drives both `hs_en` and `ls_en` low after the next clock edge. The block then stays idle with both enables low, even if `pwm_cmd` is held high, until `pwm_cmd` changes level after reset.
- R2: `hs_en` and `ls_en` are never high in the same cycle.
- R3: On the clock edge that samples a new `pwm_cmd` level, both enables go low.
- R4: On a rise of `pwm_cmd` with `ls_gate_low` already high, `hs_en` goes high on edge DEAD_CYC+2, counting the edge that samples the new level as edge 1. If `ls_gate_low` rises later, `hs_en` goes high on edge DEAD_CYC+3, counting the first edge that samples the flag high as edge 1.
- R5: When `mode_sym`=1, a fall of `pwm_cmd` waits only on `hs_gate_low`. `sw_node_low` has no effect. `ls_en` goes high DEAD_CYC+3 edges after `hs_gate_low` rises.
- R6: When `mode_sym`=0, a fall of `pwm_cmd` with `sw_node_low` already high enables `ls_en` on edge DEAD_CYC+2.
- R7: When `mode_sym`=0, a fall with `hs_gate_low`=1 and `sw_node_low`=0 starts a timeout. `ls_en` goes high on edge TMO_CYC+2, with no short delay added.
- R8: If `sw_node_low` rises while the timeout runs, the short-delay path takes over. `ls_en` goes high DEAD_CYC+3 edges after the flag rises.
- R9: When `mode_sym`=0, after a fall with both `hs_gate_low` and `sw_node_low` low, `ls_en` stays low.
- R10: A change of `pwm_cmd` before a turn-on completes cancels it. The cancelled gate is never enabled, and the sequence for the new level runs with the normal latency.
- R11: The rising-edge sequence is the same in both modes: it waits on `ls_gate_low` even when `mode_sym`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sym | input | 1 | 1 = symmetric monitoring, 0 = switch-node monitoring on the falling edge |
| pwm_cmd | input | 1 | Pulse-width command, 1 = high side on |
| ls_gate_low | input | 1 | Low-side gate below its turn-off level (asynchronous) |
| hs_gate_low | input | 1 | High-side gate below its turn-off level (asynchronous) |
| sw_node_low | input | 1 | Switch node below its low threshold (asynchronous) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Some properties are checked on every cycle: the two enables never overlap, each enable only follows a command at its own level, both enables drop on the edge that samples a command change, and reset clears both. The scenarios alone show the closed-loop behaviour. They measure the exact latency through the synchronizers and delay counters, show that an unwatched flag is ignored in symmetric mode, and cover the timeout path, the switch node taking over mid-timeout, the indefinite wait when no flag arrives, and aborts in the middle of a sequence.

// File: rtl/dtseq_pkg.sv
`timescale 1ns/1ps
package dtseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RISE_WAIT,
    ST_RISE_DLY,
    ST_HS_ON,
    ST_FALL_WAIT,
    ST_FALL_DLY,
    ST_FALL_TMO,
    ST_LS_ON
  } seq_state_t;

  // flag vector bit positions
  localparam int FL_LS = 0;
  localparam int FL_HS = 1;
  localparam int FL_SW = 2;
  localparam int N_FL  = 3;
endpackage

// File: rtl/dtseq_sync.sv
`timescale 1ns/1ps
module dtseq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async[g]};
      end
      assign q_sync[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dtseq_edge.sv
`timescale 1ns/1ps
module dtseq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic changed
);
  logic lvl_q;
  // during reset the tracker follows the input, so no edge is seen on release
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= lvl_in;
    else     lvl_q <= lvl_in;
  end
  assign changed = rst ? 1'b0 : (lvl_in ^ lvl_q);
endmodule

// File: rtl/dtseq_timer.sv
`timescale 1ns/1ps
module dtseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end
  assign done = (cnt == last);
endmodule

// File: rtl/dtseq_fsm.sv
`timescale 1ns/1ps
module dtseq_fsm
  import dtseq_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int TMO_CYC  = 100,
  parameter int CW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sym,
  input  logic          pwm_lvl,
  input  logic          pwm_chg,
  input  logic [N_FL-1:0] flags,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_last,
  output logic          hs_en,
  output logic          ls_en
);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);

  seq_state_t st, st_n;
  logic ls_low, hs_low, sw_low;

  assign ls_low = flags[FL_LS];
  assign hs_low = flags[FL_HS];
  assign sw_low = flags[FL_SW];

  always_comb begin
    st_n = st;
    if (pwm_chg) begin
      st_n = pwm_lvl ? ST_RISE_WAIT : ST_FALL_WAIT;
    end else begin
      case (st)
        ST_RISE_WAIT: if (ls_low)   st_n = ST_RISE_DLY;
        ST_RISE_DLY:  if (tmr_done) st_n = ST_HS_ON;
        ST_FALL_WAIT: begin
          if (mode_sym) begin
            if (hs_low) st_n = ST_FALL_DLY;
          end else if (sw_low) begin
            st_n = ST_FALL_DLY;
          end else if (hs_low) begin
            st_n = ST_FALL_TMO;
          end
        end
        ST_FALL_TMO: begin
          if (sw_low)        st_n = ST_FALL_DLY;
          else if (tmr_done) st_n = ST_LS_ON;
        end
        ST_FALL_DLY:  if (tmr_done) st_n = ST_LS_ON;
        default:      st_n = st;
      endcase
    end
  end

  assign tmr_clr  = (st_n != st);
  assign tmr_last = (st == ST_FALL_TMO) ? TMO_LAST : DEAD_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      st    <= st_n;
      hs_en <= (st_n == ST_HS_ON);
      ls_en <= (st_n == ST_LS_ON);
    end
  end
endmodule

// File: rtl/dt_gate_sequencer.sv
`timescale 1ns/1ps
module dt_gate_sequencer
  import dtseq_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int TMO_CYC  = 100,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sym,
  input  logic pwm_cmd,
  input  logic ls_gate_low,
  input  logic hs_gate_low,
  input  logic sw_node_low,
  output logic hs_en,
  output logic ls_en
);
  localparam int MAXC = (DEAD_CYC > TMO_CYC) ? DEAD_CYC : TMO_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [N_FL-1:0] fl_raw, fl_s;
  logic            pwm_chg, tmr_clr, tmr_done;
  logic [CW-1:0]   tmr_last;

  assign fl_raw[FL_LS] = ls_gate_low;
  assign fl_raw[FL_HS] = hs_gate_low;
  assign fl_raw[FL_SW] = sw_node_low;

  dtseq_sync #(.WIDTH(N_FL), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(fl_raw), .q_sync(fl_s)
  );

  dtseq_edge u_edge (
    .clk(clk), .rst(rst), .lvl_in(pwm_cmd), .changed(pwm_chg)
  );

  dtseq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .last(tmr_last), .done(tmr_done)
  );

  dtseq_fsm #(.DEAD_CYC(DEAD_CYC), .TMO_CYC(TMO_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .mode_sym(mode_sym), .pwm_lvl(pwm_cmd),
    .pwm_chg(pwm_chg), .flags(fl_s), .tmr_done(tmr_done),
    .tmr_clr(tmr_clr), .tmr_last(tmr_last), .hs_en(hs_en), .ls_en(ls_en)
  );
endmodule

// File: rtl/dtseq_checker.sv
`timescale 1ns/1ps
module dtseq_checker (
  input logic clk,
  input logic rst,
  input logic pwm_cmd,
  input logic hs_en,
  input logic ls_en
);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  a_r2_break_first: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> !$past(ls_en));

  a_r2_break_first_ls: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> !$past(hs_en));

  a_r3_off_on_change: assert property (@(posedge clk) disable iff (rst)
    (pwm_cmd != $past(pwm_cmd)) |=> (!hs_en && !ls_en));

  a_r10_hs_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    hs_en |-> $past(pwm_cmd));

  a_r10_ls_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    ls_en |-> !$past(pwm_cmd));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!hs_en && !ls_en));
endmodule

bind dt_gate_sequencer dtseq_checker u_chk (
  .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/sim_dt_gate_sequencer.sv
`timescale 1ns/1ps
module sim_dt_gate_sequencer;
  localparam int DEAD = 2;
  localparam int TMO  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sym = 1'b1;
  logic pwm_cmd = 1'b0;
  logic ls_gate_low = 1'b0, hs_gate_low = 1'b0, sw_node_low = 1'b0;
  logic hs_en, ls_en;

  int n_chk = 0, n_fail = 0, n_ovl = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dt_gate_sequencer #(.DEAD_CYC(DEAD), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .mode_sym(mode_sym), .pwm_cmd(pwm_cmd),
    .ls_gate_low(ls_gate_low), .hs_gate_low(hs_gate_low),
    .sw_node_low(sw_node_low), .hs_en(hs_en), .ls_en(ls_en)
  );

  always @(negedge clk) if (!rst && hs_en && ls_en) n_ovl++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // count edges until target enable is seen; other = opposite enable seen meanwhile
  task automatic meas(input bit tgt_hs, input int lim, output int n, output bit other);
    bit found = 0;
    n = 0; other = 0;
    for (int i = 0; i < lim && !found; i++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (tgt_hs ? ls_en : hs_en) other = 1;
      if (tgt_hs ? hs_en : ls_en) found = 1;
    end
    if (!found) n = -1;
  endtask

  task automatic set_flags(input bit l, input bit h, input bit s);
    ls_gate_low = l; hs_gate_low = h; sw_node_low = s;
    cyc(3);
  endtask

  task automatic to_hs();
    set_flags(1, 0, 0);
    pwm_cmd = 1; cyc(DEAD + 6);
  endtask

  task automatic to_ls();
    mode_sym = 1; set_flags(0, 1, 0);
    pwm_cmd = 0; cyc(DEAD + 6);
  endtask

  task automatic t_reset();
    int n; bit o;
    pwm_cmd = 1; rst = 1; cyc(3); rst = 0;
    cyc(10);
    chk(!hs_en && !ls_en, "R1 idle after reset with pwm high", {hs_en, ls_en}, 0);
    mode_sym = 1; set_flags(0, 1, 0);
    pwm_cmd = 0; meas(0, 40, n, o);
    chk(n == DEAD + 2, "R1 first edge from idle", n, DEAD + 2);
    to_hs();
    chk(hs_en == 1, "R4 reached high side", hs_en, 1);
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    chk(!hs_en && !ls_en, "R1 reset clears enables", {hs_en, ls_en}, 0);
    cyc(10);
    chk(!hs_en && !ls_en, "R1 no sequence without pwm change", {hs_en, ls_en}, 0);
  endtask

  task automatic t_rise_basic();
    int n; bit o;
    to_ls();
    set_flags(1, 0, 0);
    pwm_cmd = 1; meas(1, 40, n, o);
    chk(n == DEAD + 2, "R4 rise latency flag ready", n, DEAD + 2);
    chk(!o, "R2 no low side during rise", o, 0);
  endtask

  task automatic t_rise_late_flag();
    int n; bit o;
    to_ls();
    set_flags(0, 0, 0);
    pwm_cmd = 1; cyc(10);
    chk(!hs_en && !ls_en, "R4 waits for low-side flag", {hs_en, ls_en}, 0);
    ls_gate_low = 1; meas(1, 40, n, o);
    chk(n == DEAD + 3, "R4 rise latency late flag", n, DEAD + 3);
  endtask

  task automatic t_fall_sym();
    int n; bit o;
    to_hs();
    mode_sym = 1; set_flags(0, 0, 1);
    pwm_cmd = 0; @(posedge clk); @(negedge clk);
    chk(!hs_en && !ls_en, "R3 both off on change", {hs_en, ls_en}, 0);
    cyc(20);
    chk(!ls_en, "R5 switch node flag ignored", ls_en, 0);
    hs_gate_low = 1; meas(0, 40, n, o);
    chk(n == DEAD + 3, "R5 symmetric fall latency", n, DEAD + 3);
  endtask

  task automatic t_fall_asym_sw();
    int n; bit o;
    to_hs();
    mode_sym = 0; set_flags(0, 0, 1);
    pwm_cmd = 0; meas(0, 40, n, o);
    chk(n == DEAD + 2, "R6 asymmetric switch-node latency", n, DEAD + 2);
  endtask

  task automatic t_timeout();
    int n; bit o;
    to_hs();
    mode_sym = 0; set_flags(0, 1, 0);
    pwm_cmd = 0; meas(0, 60, n, o);
    chk(n == TMO + 2, "R7 timeout latency", n, TMO + 2);
  endtask

  task automatic t_tmo_sw_mid();
    int n; bit o;
    to_hs();
    mode_sym = 0; set_flags(0, 1, 0);
    pwm_cmd = 0; cyc(6);
    chk(!ls_en, "R8 still timing", ls_en, 0);
    sw_node_low = 1; meas(0, 60, n, o);
    chk(n == DEAD + 3, "R8 switch node ends timeout", n, DEAD + 3);
  endtask

  task automatic t_stuck();
    to_hs();
    mode_sym = 0; set_flags(0, 0, 0);
    pwm_cmd = 0; cyc(50);
    chk(!hs_en && !ls_en, "R9 no flag no turn-on", {hs_en, ls_en}, 0);
  endtask

  task automatic t_abort();
    int n; bit o;
    to_ls();
    mode_sym = 1; set_flags(0, 1, 0);
    pwm_cmd = 1; cyc(5);
    chk(!hs_en, "R10 rise pending", hs_en, 0);
    pwm_cmd = 0; meas(0, 40, n, o);
    chk(n == DEAD + 2 && !o, "R10 abort rise then fall", n, DEAD + 2);
    to_hs();
    mode_sym = 0; set_flags(1, 1, 0);
    pwm_cmd = 0; cyc(5);
    pwm_cmd = 1; meas(1, 40, n, o);
    chk(n == DEAD + 2 && !o, "R10 abort timeout then rise", n, DEAD + 2);
  endtask

  task automatic t_rise_asym();
    int n; bit o;
    to_ls();
    mode_sym = 0; set_flags(0, 0, 1);
    pwm_cmd = 1; cyc(10);
    chk(!hs_en, "R11 asym rise ignores switch node", hs_en, 0);
    ls_gate_low = 1; meas(1, 40, n, o);
    chk(n == DEAD + 3, "R11 asym rise latency", n, DEAD + 3);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    cyc(1);
    chk(!hs_en && !ls_en, "R1 reset state", {hs_en, ls_en}, 0);
    t_reset();
    t_rise_basic();
    t_rise_late_flag();
    t_fall_sym();
    t_fall_asym_sw();
    t_timeout();
    t_tmo_sw_mid();
    t_stuck();
    t_abort();
    t_rise_asym();
    chk(n_ovl == 0, "R2 overlap cycles", n_ovl, 0);
    finish_run();
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end
endmodule